// File: doc/BRIEF.md
# Rise/Fall Point PWM Generator

This block produces several PWM outputs whose timing comes from a small set of shared clock types. Each clock type divides the system clock in two stages, a linear stage and a power-of-two stage, into a tick. It also carries an 8-bit period count. A channel counts ticks of its chosen type from 0 up to that period and then starts again at 0.

Within each period, a channel's output is shaped by two 8-bit points. The output turns on at the rising point and turns off at the falling point. This allows any duty cycle and any phase inside the period.

Software programs the block through a single-cycle write port. Address 0 is the channel control word. The next addresses hold one configuration word per clock type. The addresses after those hold one duty word per pair of channels. New rising and falling points are staged and take effect only at a period boundary, so a rewrite never produces a clipped or doubled pulse. Setting the enable bit low gives zero duty. Setting the two points equal gives full duty.

Top module: `edge_point_pwm`

## Requirements
- R1: While rst_n is low at a clock edge, all registers clear. From then until a write enables a channel, every pwm_out bit stays 0.
- R2: The configuration word for clock type k is at address 1+k, with period P in bits 7:0, high exponent H in bits 11:8 and low divisor L in bits 19:16. The type ticks once every 2^H × D clock cycles, where D = 1 when L = 0 and D = 2L otherwise. Writing the word restarts the type's divider.
- R3: A running channel's output repeats every (P+1) ticks. Its counter goes from P, or from any value above P, back to 0.
- R4: When rise < fall, the output is high while rise ≤ count < fall, which is (fall−rise) ticks per period.
- R5: When rise equals fall (including both 0), the output stays high for the whole period.
- R6: When rise > fall, the output is high while count ≥ rise or count < fall, which is (P+1−(rise−fall)) ticks, one pulse across the wrap.
- R7: While bit i of the control word at address 0 is clear, channel i drives 0, its counter is held at 0 and its staged points are loaded. When the bit is set again, the channel starts a fresh period at count 0.
- R8: Bits [9+2i:8+2i] of the control word choose channel i's clock type: code 0, 1 or 2 selects that type, and code 3 keeps the output at 0.
- R9: The duty word for channel pair p is at address 4+p (with three types). Channel 2p takes rise from bits 7:0 and fall from bits 15:8. Channel 2p+1 takes rise from bits 23:16 and fall from bits 31:24.
- R10: Points written in mid-period do not change the current period. They apply from the next count-0 boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one word per cycle |
| wr_addr | input | ADDR_W (4) | Word address of the write |
| wr_data | input | DATA_W (32) | Write data |
| pwm_out | output | NUM_CH (4) | One PWM output per channel |

## Verification
A fault in a clock type's divider changes the spacing of every pulse edge on all channels using that type, within one tick. Measuring high and low run lengths in clock cycles therefore exposes it within two periods.

A counter that wraps at the wrong value changes the sum of the high and low runs. An active point register that loads at the wrong moment shortens or stretches the pulse in progress. The mid-period rewrite scenario shows this in the very pulse being rewritten.

A wrong enable or type decode shows as an output that does not drop to 0, or a first pulse after re-enabling that is shorter than a full high run.

// File: rtl/epw_pkg.sv
// Package: shared codes and register layout constants for the rise/fall
// point PWM block. Assumes 32-bit write data.
package epw_pkg;

    // Clock type selection code per channel; the last code parks the channel.
    typedef enum logic [1:0] {
        TSEL_A   = 2'd0,
        TSEL_B   = 2'd1,
        TSEL_C   = 2'd2,
        TSEL_OFF = 2'd3
    } tsel_e;

    // Word addresses and field positions.
    localparam int CTRL_ADDR     = 0;
    localparam int CLK_BASE      = 1;
    localparam int CTRL_TSEL_LSB = 8;
    localparam int CFG_PER_LSB   = 0;
    localparam int CFG_HEXP_LSB  = 8;
    localparam int CFG_LDIV_LSB  = 16;
    localparam int HALF_W        = 16;
    localparam int FALL_OFS      = 8;

endpackage

// File: rtl/epw_regs.sv
// Module: register file of the PWM block.
// Holds the channel control word, one configuration word per clock type and
// the staged rising/falling points of each channel. It emits a one-cycle
// restart pulse for a clock type whose word was written.
// Assumes PER_W <= 8 so that a point fits its byte in the duty word.
module epw_regs
    import epw_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_TYPES = 3,
    parameter int PER_W     = 8,
    parameter int HEXP_W    = 4,
    parameter int LDIV_W    = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NUM_CH-1:0]             ch_en,
    output logic [2*NUM_CH-1:0]           ch_tsel,
    output logic [NUM_TYPES*PER_W-1:0]    ty_per,
    output logic [NUM_TYPES*HEXP_W-1:0]   ty_hexp,
    output logic [NUM_TYPES*LDIV_W-1:0]   ty_ldiv,
    output logic [NUM_TYPES-1:0]          ty_restart,
    output logic [NUM_CH*PER_W-1:0]       ch_rise,
    output logic [NUM_CH*PER_W-1:0]       ch_fall
);

    localparam int DUTY_BASE = CLK_BASE + NUM_TYPES;

    logic ctrl_hit;
    assign ctrl_hit = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

    // Control word: enables and clock type codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_en   <= '0;
            ch_tsel <= '0;
        end else if (ctrl_hit) begin
            ch_en   <= wr_data[NUM_CH-1:0];
            ch_tsel <= wr_data[CTRL_TSEL_LSB +: 2*NUM_CH];
        end
    end

    for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
        logic              hit;
        logic [PER_W-1:0]  per_q;
        logic [HEXP_W-1:0] hexp_q;
        logic [LDIV_W-1:0] ldiv_q;
        logic              rst_q;

        assign hit = wr_en && (wr_addr == ADDR_W'(CLK_BASE + t));

        // Clock type word and its divider restart pulse.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                per_q  <= '0;
                hexp_q <= '0;
                ldiv_q <= '0;
                rst_q  <= 1'b0;
            end else begin
                rst_q <= hit;
                if (hit) begin
                    per_q  <= wr_data[CFG_PER_LSB  +: PER_W];
                    hexp_q <= wr_data[CFG_HEXP_LSB +: HEXP_W];
                    ldiv_q <= wr_data[CFG_LDIV_LSB +: LDIV_W];
                end
            end
        end

        assign ty_per [t*PER_W  +: PER_W]  = per_q;
        assign ty_hexp[t*HEXP_W +: HEXP_W] = hexp_q;
        assign ty_ldiv[t*LDIV_W +: LDIV_W] = ldiv_q;
        assign ty_restart[t]               = rst_q;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_pts
        localparam int PAIR = i / 2;
        localparam int HALF = i % 2;
        logic             hit;
        logic [PER_W-1:0] rise_q;
        logic [PER_W-1:0] fall_q;

        assign hit = wr_en && (wr_addr == ADDR_W'(DUTY_BASE + PAIR));

        // Staged points of this channel, taken from its half of the pair word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rise_q <= '0;
                fall_q <= '0;
            end else if (hit) begin
                rise_q <= wr_data[HALF*HALF_W +: PER_W];
                fall_q <= wr_data[HALF*HALF_W + FALL_OFS +: PER_W];
            end
        end

        assign ch_rise[i*PER_W +: PER_W] = rise_q;
        assign ch_fall[i*PER_W +: PER_W] = fall_q;
    end

    // A single write touches at most one clock type word (R2).
    p_one_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ty_restart))
        else $error("more than one clock type restarted");

endmodule

// File: rtl/epw_clkgen.sv
// Module: tick generator of one clock type.
// A linear stage pulses every D cycles, where D is 1 for L = 0 and 2L otherwise.
// A power-of-two stage passes every 2^H-th pulse on as a one-cycle tick.
// Both stages clear on a restart pulse; no tick is issued in that cycle.
module epw_clkgen #(
    parameter int HEXP_W = 4,
    parameter int LDIV_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [HEXP_W-1:0] hexp,
    input  logic [LDIV_W-1:0] ldiv,
    output logic              tick
);

    localparam int L1_W    = LDIV_W + 1;
    localparam int H_CNT_W = (1 << HEXP_W) - 1;

    logic [L1_W-1:0]    c1_q;
    logic [L1_W-1:0]    l_last;
    logic               p1;
    logic [H_CNT_W-1:0] c2_q;
    logic [H_CNT_W-1:0] mask;

    assign l_last = {ldiv, 1'b0} - L1_W'(1);
    assign p1     = (ldiv == '0) || (c1_q == l_last);
    assign mask   = ~({H_CNT_W{1'b1}} << hexp);
    assign tick   = !restart && p1 && ((c2_q & mask) == mask);

    // Linear stage counter.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || p1) begin
            c1_q <= '0;
        end else begin
            c1_q <= c1_q + L1_W'(1);
        end
    end

    // Power-of-two stage counter, advanced by each linear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            c2_q <= '0;
        end else if (p1) begin
            c2_q <= c2_q + H_CNT_W'(1);
        end
    end

    // Any divisor above one leaves at least one idle cycle after a tick (R2).
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (hexp != '0 || ldiv != '0)) |=> !tick)
        else $error("ticks too close for divisor");

endmodule

// File: rtl/epw_chan.sv
// Module: one PWM channel.
// Selects a clock type and counts its ticks from 0 to the period.
// Drives high between the active rising and falling points.
// Active points reload from the staged ones only at the wrap, or while the
// channel is not running.
// Assumes tick is a one-cycle pulse.
module epw_chan
    import epw_pkg::*;
#(
    parameter int NUM_TYPES = 3,
    parameter int PER_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic [1:0]                 tsel,
    input  logic [NUM_TYPES-1:0]       tick_all,
    input  logic [NUM_TYPES*PER_W-1:0] per_all,
    input  logic [PER_W-1:0]           rise_s,
    input  logic [PER_W-1:0]           fall_s,
    output logic                       pwm_out
);

    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] rise_a;
    logic [PER_W-1:0] fall_a;
    logic [PER_W-1:0] per_c;
    logic             tick_c;
    logic             sel_ok;
    logic             run;
    logic             at_end;
    logic             level;

    // Pick the tick and period of the selected clock type.
    always_comb begin
        tick_c = 1'b0;
        per_c  = '0;
        for (int t = 0; t < NUM_TYPES; t++) begin
            if (int'(tsel) == t) begin
                tick_c = tick_all[t];
                per_c  = per_all[t*PER_W +: PER_W];
            end
        end
    end

    assign sel_ok = (tsel != TSEL_OFF) && (int'(tsel) < NUM_TYPES);
    assign run    = en && sel_ok;
    assign at_end = tick_c && (cnt_q >= per_c);

    // Tick counter and active point registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rise_a <= '0;
            fall_a <= '0;
        end else if (!run || at_end) begin
            cnt_q  <= '0;
            rise_a <= rise_s;
            fall_a <= fall_s;
        end else if (tick_c) begin
            cnt_q <= cnt_q + PER_W'(1);
        end
    end

    // Output level as a function of count position and points.
    always_comb begin
        if (rise_a == fall_a) begin
            level = 1'b1;
        end else if (rise_a < fall_a) begin
            level = (cnt_q >= rise_a) && (cnt_q < fall_a);
        end else begin
            level = (cnt_q >= rise_a) || (cnt_q < fall_a);
        end
    end

    assign pwm_out = run && level;

    // Counter returns to zero after a tick at or beyond the period (R3).
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && at_end) |=> (cnt_q == '0))
        else $error("counter did not wrap");

    // Active points only move at the wrap or while parked (R10).
    p_points_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !at_end) |=> ($stable(rise_a) && $stable(fall_a)))
        else $error("points changed inside a period");

    // Equal points keep a running output high (R5).
    p_full_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && rise_a == fall_a) |-> pwm_out)
        else $error("equal points not full duty");

    // A cleared enable forces the output low (R7).
    p_disabled_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !pwm_out)
        else $error("disabled channel active");

    // The park code keeps the output low (R8).
    p_off_code_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tsel == TSEL_OFF) |-> !pwm_out)
        else $error("parked channel active");

endmodule

// File: rtl/edge_point_pwm.sv
// Module: top of the rise/fall point PWM block.
// Connects the register file, one tick generator per clock type and one
// channel per output.
// Assumes the control word can hold all enables and type codes.
module edge_point_pwm
    import epw_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_TYPES = 3,
    parameter int PER_W     = 8,
    parameter int HEXP_W    = 4,
    parameter int LDIV_W    = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [NUM_CH-1:0]           ch_en;
    logic [2*NUM_CH-1:0]         ch_tsel;
    logic [NUM_TYPES*PER_W-1:0]  ty_per;
    logic [NUM_TYPES*HEXP_W-1:0] ty_hexp;
    logic [NUM_TYPES*LDIV_W-1:0] ty_ldiv;
    logic [NUM_TYPES-1:0]        ty_restart;
    logic [NUM_TYPES-1:0]        ty_tick;
    logic [NUM_CH*PER_W-1:0]     ch_rise;
    logic [NUM_CH*PER_W-1:0]     ch_fall;

    epw_regs #(
        .NUM_CH(NUM_CH), .NUM_TYPES(NUM_TYPES), .PER_W(PER_W),
        .HEXP_W(HEXP_W), .LDIV_W(LDIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ch_en(ch_en), .ch_tsel(ch_tsel),
        .ty_per(ty_per), .ty_hexp(ty_hexp), .ty_ldiv(ty_ldiv),
        .ty_restart(ty_restart), .ch_rise(ch_rise), .ch_fall(ch_fall)
    );

    for (genvar t = 0; t < NUM_TYPES; t++) begin : g_clk
        epw_clkgen #(.HEXP_W(HEXP_W), .LDIV_W(LDIV_W)) u_clkgen (
            .clk(clk), .rst_n(rst_n), .restart(ty_restart[t]),
            .hexp(ty_hexp[t*HEXP_W +: HEXP_W]),
            .ldiv(ty_ldiv[t*LDIV_W +: LDIV_W]),
            .tick(ty_tick[t])
        );
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        epw_chan #(.NUM_TYPES(NUM_TYPES), .PER_W(PER_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .en(ch_en[i]),
            .tsel(ch_tsel[2*i +: 2]), .tick_all(ty_tick), .per_all(ty_per),
            .rise_s(ch_rise[i*PER_W +: PER_W]),
            .fall_s(ch_fall[i*PER_W +: PER_W]),
            .pwm_out(pwm_out[i])
        );
    end

endmodule

// File: tb/edge_point_pwm_bench.sv
// Directed bench: one task per scenario. Pulse run lengths are measured in
// clock cycles at falling clock edges.
module edge_point_pwm_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  pwm_out;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] ctrl_sh = '0;
    logic [31:0] duty_sh [2];

    always #10 clk = ~clk;

    edge_point_pwm u_edge_point_pwm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic reg_write(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_clk(input int t, input int per, input int h, input int l);
        reg_write(1 + t, (32'(l) << 16) | (32'(h) << 8) | 32'(per));
    endtask

    task automatic set_chan(input int ch, input logic en, input int ts);
        ctrl_sh[ch] = en;
        ctrl_sh[8 + 2*ch +: 2] = 2'(ts);
        reg_write(0, ctrl_sh);
    endtask

    task automatic set_points(input int ch, input int r, input int f);
        duty_sh[ch/2][(ch%2)*16 +: 16] = {8'(f), 8'(r)};
        reg_write(4 + ch/2, duty_sh[ch/2]);
    endtask

    // Count consecutive samples at level lvl, starting at the current one.
    task automatic run_len(input int ch, input logic lvl, output int n);
        n = 0;
        while (pwm_out[ch] === lvl && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Advance to the first high sample after a low one.
    task automatic wait_rise(input int ch);
        int g = 0;
        @(negedge clk);
        while (pwm_out[ch] !== 1'b0 && g < 5000) begin g++; @(negedge clk); end
        while (pwm_out[ch] !== 1'b1 && g < 10000) begin g++; @(negedge clk); end
    endtask

    // Measure the second full high/low pair after a rise.
    task automatic measure(input int ch, output int hi, output int lo);
        int d;
        wait_rise(ch);
        run_len(ch, 1'b1, d);
        run_len(ch, 1'b0, d);
        run_len(ch, 1'b1, hi);
        run_len(ch, 1'b0, lo);
    endtask

    task automatic count_high(input int ch, input int cyc, output int n);
        n = 0;
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            if (pwm_out[ch] === 1'b1) n++;
        end
    endtask

    task automatic t_reset();
        int n = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (pwm_out !== 4'b0) n++;
        end
        rst_n = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (pwm_out !== 4'b0) n++;
        end
        check_eq("R1 outputs low through and after reset", n, 0);
    endtask

    task automatic t_basic();
        int hi, lo;
        set_points(0, 0, 10);
        set_clk(0, 19, 0, 0);
        set_chan(0, 1'b1, 0);
        measure(0, hi, lo);
        check_eq("R4 high run rise0 fall10", hi, 10);
        check_eq("R3 period 20 ticks", hi + lo, 20);
    endtask

    task automatic t_prescale();
        int hi, lo;
        set_points(0, 1, 3);
        set_clk(0, 4, 1, 2);
        measure(0, hi, lo);
        check_eq("R2 H1 L2 high run", hi, 16);
        check_eq("R3 H1 L2 period", hi + lo, 40);
        set_clk(0, 4, 2, 0);
        measure(0, hi, lo);
        check_eq("R2 H2 L0 high run", hi, 8);
        check_eq("R2 H2 L0 low run", lo, 12);
    endtask

    task automatic t_wrap();
        int hi, lo;
        set_clk(0, 4, 1, 2);
        set_points(0, 3, 1);
        measure(0, hi, lo);
        check_eq("R6 wrapped high run", hi, 24);
        check_eq("R6 wrapped low run", lo, 16);
    endtask

    task automatic t_full();
        int n;
        set_clk(0, 19, 0, 0);
        set_points(0, 0, 0);
        repeat (50) @(negedge clk);
        count_high(0, 100, n);
        check_eq("R5 rise0 fall0 constant high", n, 100);
        set_points(0, 7, 7);
        repeat (50) @(negedge clk);
        count_high(0, 100, n);
        check_eq("R5 rise7 fall7 constant high", n, 100);
    endtask

    task automatic t_pair();
        int hi, lo;
        set_clk(0, 19, 0, 0);
        set_points(0, 0, 15);
        set_points(1, 2, 6);
        set_chan(1, 1'b1, 0);
        measure(1, hi, lo);
        check_eq("R9 upper half channel high run", hi, 4);
        check_eq("R9 upper half channel low run", lo, 16);
        measure(0, hi, lo);
        check_eq("R9 lower half channel high run", hi, 15);
    endtask

    task automatic t_typesel();
        int hi, lo, n;
        set_clk(1, 9, 0, 0);
        set_clk(2, 9, 0, 1);
        set_points(2, 0, 3);
        set_points(3, 2, 7);
        set_chan(2, 1'b1, 1);
        set_chan(3, 1'b1, 2);
        measure(2, hi, lo);
        check_eq("R8 type 1 high run", hi, 3);
        check_eq("R8 type 1 low run", lo, 7);
        measure(3, hi, lo);
        check_eq("R8 type 2 high run", hi, 10);
        check_eq("R8 type 2 period", hi + lo, 20);
        set_chan(3, 1'b1, 3);
        count_high(3, 100, n);
        check_eq("R8 park code output low", n, 0);
    endtask

    task automatic t_boundary();
        int n1, n0, n2;
        set_clk(0, 19, 0, 0);
        set_points(0, 0, 10);
        repeat (45) @(negedge clk);
        wait_rise(0);
        fork
            run_len(0, 1'b1, n1);
            begin
                repeat (2) @(negedge clk);
                set_points(0, 0, 5);
            end
        join
        run_len(0, 1'b0, n0);
        run_len(0, 1'b1, n2);
        check_eq("R10 pulse in progress unchanged", n1, 10);
        check_eq("R10 rest of period unchanged", n0, 10);
        check_eq("R10 new fall from next period", n2, 5);
    endtask

    task automatic t_disable();
        int n;
        set_points(0, 0, 10);
        repeat (45) @(negedge clk);
        wait_rise(0);
        repeat (3) @(negedge clk);
        set_chan(0, 1'b0, 0);
        count_high(0, 30, n);
        check_eq("R7 disabled output low", n, 0);
        set_chan(0, 1'b1, 0);
        run_len(0, 1'b1, n);
        check_eq("R7 re-enable starts at count 0", n, 10);
    endtask

    initial begin
        duty_sh[0] = '0;
        duty_sh[1] = '0;
        t_reset();
        t_basic();
        t_prescale();
        t_wrap();
        t_full();
        t_pair();
        t_typesel();
        t_boundary();
        t_disable();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule